// File: doc/BRIEF.md
# Programmable Microcycle Delay Sequencer

This block carries out a timed stall of the kind a small processor uses to wait for a slow peripheral. A caller presents an 8-bit delay parameter `P` and the current 8-bit accumulator value `AC`, then pulses `start`. The block holds `busy` high while it counts 13 + 514·P + 2·AC microcycles. It then pulses `done` for one clock and releases `busy`.

Time is measured in microcycles. A microcycle is one clock on which the `ucyc_tick` enable is high. Clocks without the enable do not advance the stall.

The accumulator is used up as part of the wait. It drops by one on every second counted microcycle until it reaches zero. Its running value is driven on `acc_out` throughout the stall, and the final value (zero) stays on that output after `done`.

Top module: `ucyc_delay_seq`

## Requirements
- R1: After reset, `busy`, `done` and `acc_out` are all zero.
- R2: A `start` sampled high on a clock edge while `busy` is low is accepted, and `busy` is high from the next cycle on. A `ucyc_tick` on the clock edge that accepts the start is not counted.
- R3: Let N = 13 + 514·P + 2·AC, computed from the `param_in` and `acc_in` values sampled with the accepted start. The block counts exactly N edges on which both `busy` and `ucyc_tick` are high. On the edge that takes the N-th tick, `busy` falls and `done` rises together.
- R4: `done` is high for exactly one clock per stall, and only with `busy` low.
- R5: Clock edges with `ucyc_tick` low leave the stall length and `acc_out` unchanged. The stall length therefore depends only on the number of ticks, not on the spacing between them.
- R6: While busy, after k counted ticks, `acc_out` equals max(AC − floor(k/2), 0).
- R7: When `done` is high, `acc_out` is zero. It keeps that value until the next accepted start.
- R8: A `start` while `busy` is high is ignored. The stall length and the accumulator countdown of the running stall are unchanged.
- R9: A `start` on the cycle in which `done` is high is accepted, so one stall can follow another with no idle cycle between them.
- R10: The shortest stall is 13 ticks (P = 0, AC = 0). The longest is 131,593 ticks (P = 255, AC = 255).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ucyc_tick | input | 1 | Microcycle enable, one clock wide |
| start | input | 1 | Request a stall |
| param_in | input | 8 | Delay parameter P, sampled with an accepted start |
| acc_in | input | 8 | Accumulator value AC, sampled with an accepted start |
| busy | output | 1 | Stall in progress |
| done | output | 1 | One-clock pulse when the stall ends |
| acc_out | output | 8 | Running, then final, accumulator value |

## Verification
Two pairs of events can fall in the same cycle. The first pair is the completion pulse and the acceptance of a new start. The bench provokes it by driving `start` in the very cycle it observes `done`. It then judges the result from three things: `busy` is high one cycle later, the new stall's own tick count, and the accumulator reload. The second pair is a start request arriving while ticks are still being counted. That request must lose to the running stall, which the scoreboard confirms through an unchanged total and an unchanged accumulator trajectory.

// File: rtl/ucyc_delay_pkg.sv
package ucyc_delay_pkg;

  // Stall length in microcycles: fixed + p*(lin + 2^shift) + ac*acmul
  function automatic int unsigned stall_len(
    input int unsigned p,
    input int unsigned ac,
    input int unsigned fixed_part,
    input int unsigned p_lin,
    input int unsigned p_shift,
    input int unsigned ac_mul
  );
    return fixed_part + p * p_lin + (p << p_shift) + ac * ac_mul;
  endfunction

  // Width needed to hold a non-negative value v
  function automatic int unsigned bits_for(input int unsigned v);
    int unsigned n;
    n = 1;
    while ((v >> n) != 0) n++;
    return n;
  endfunction

endpackage

// File: rtl/ucyc_tick_cnt.sv
module ucyc_tick_cnt #(
  parameter int unsigned CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             busy,
  input  logic             tick,
  output logic             last_tick
);

  logic [CNT_W-1:0] remaining;
  logic             step;

  assign step      = busy && tick;
  assign last_tick = step && (remaining == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)        remaining <= '0;
    else if (load)     remaining <= load_val;
    else if (step)     remaining <= remaining - CNT_W'(1);
  end

  // R5: no tick, no progress
  p_hold_without_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick && !load) |=> $stable(remaining));

  // R3: a running stall never has an empty count
  p_remaining_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (remaining != '0));

endmodule

// File: rtl/ucyc_acc_cnt.sv
module ucyc_acc_cnt #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              step,
  output logic [DATA_W-1:0] acc
);

  logic half;
  logic live;

  assign live = step && (acc != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc  <= '0;
      half <= 1'b0;
    end else if (load) begin
      acc  <= load_val;
      half <= 1'b0;
    end else if (live) begin
      half <= ~half;
      if (half) acc <= acc - DATA_W'(1);
    end
  end

  // R6: a decrement happens on the second tick of each pair
  p_pair_decrement_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (live && half && !load) |=> (acc == $past(acc) - DATA_W'(1)));

  // R5: without a step or load the accumulator holds
  p_acc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(acc));

endmodule

// File: rtl/ucyc_delay_seq.sv
module ucyc_delay_seq #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned FIXED_TICKS = 13,
  parameter int unsigned P_LIN       = 2,
  parameter int unsigned P_SHIFT     = 9,
  parameter int unsigned AC_MUL      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ucyc_tick,
  input  logic              start,
  input  logic [DATA_W-1:0] param_in,
  input  logic [DATA_W-1:0] acc_in,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] acc_out
);
  import ucyc_delay_pkg::*;

  localparam int unsigned MAX_IN    = (1 << DATA_W) - 1;
  localparam int unsigned MAX_STALL = stall_len(MAX_IN, MAX_IN, FIXED_TICKS,
                                                P_LIN, P_SHIFT, AC_MUL);
  localparam int unsigned CNT_W     = bits_for(MAX_STALL);

  // named internal events
  logic             accept;
  logic             last_tick;
  logic             counted;
  logic [CNT_W-1:0] total;

  assign accept  = start && !busy;
  assign counted = busy && ucyc_tick;
  assign total   = CNT_W'(stall_len(int'(param_in), int'(acc_in), FIXED_TICKS,
                                    P_LIN, P_SHIFT, AC_MUL));

  ucyc_tick_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_val  (total),
    .busy      (busy),
    .tick      (ucyc_tick),
    .last_tick (last_tick)
  );

  ucyc_acc_cnt #(.DATA_W(DATA_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (acc_in),
    .step     (counted),
    .acc      (acc_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= last_tick;
      if (accept)         busy <= 1'b1;
      else if (last_tick) busy <= 1'b0;
    end
  end

  // R2: accepted start raises busy next cycle
  p_busy_follows_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  // R4: done is a single-cycle pulse with busy low
  p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R7: accumulator drained at completion
  p_acc_drained_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (acc_out == '0));

  // R8: a start while busy does not disturb the countdown
  p_ignore_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !ucyc_tick) |=> (busy && $stable(acc_out)));

endmodule

// File: tb/ucyc_delay_seq_bench.sv
module ucyc_delay_seq_bench;

  typedef struct { int unsigned p; int unsigned ac; } job_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ucyc_tick = 1'b0;
  logic       start = 1'b0;
  logic [7:0] param_in = '0;
  logic [7:0] acc_in = '0;
  logic       busy, done;
  logic [7:0] acc_out;

  int unsigned vectors = 0;
  int unsigned fails = 0;
  int unsigned tick_cnt = 0;
  int unsigned cycles = 0;
  int          tick_mode = 0;
  int unsigned phase = 0;
  logic [15:0] lf = 16'hACE1;
  job_t        sb_q[$];

  always #4 clk = ~clk;

  ucyc_delay_seq u_ucyc_delay_seq (
    .clk(clk), .rst_n(rst_n), .ucyc_tick(ucyc_tick), .start(start),
    .param_in(param_in), .acc_in(acc_in),
    .busy(busy), .done(done), .acc_out(acc_out)
  );

  function automatic int unsigned exp_len(input int unsigned p, input int unsigned ac);
    return 13 + 514 * p + 2 * ac;
  endfunction

  task automatic check(input bit ok, input string req, input int unsigned act,
                       input int unsigned expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  // monitor, tick generator and watchdog; all at the falling edge
  always @(negedge clk) begin
    int unsigned expacc;
    job_t j;
    cycles++;
    if (cycles > 195000) begin
      check(1'b0, "watchdog", cycles, 195000);
      finish_run();
    end
    if (rst_n) begin
      if (done) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R4 unexpected done", 1, 0);
        end else begin
          j = sb_q.pop_front();
          check(tick_cnt == exp_len(j.p, j.ac), "R3 R5 tick total", tick_cnt,
                exp_len(j.p, j.ac));
          check(acc_out == 8'd0, "R7 final acc", acc_out, 0);
          check(!busy, "R3 busy low at done", busy, 0);
        end
        tick_cnt = 0;
      end else if (busy && sb_q.size() != 0) begin
        j = sb_q[0];
        expacc = (j.ac > tick_cnt / 2) ? j.ac - tick_cnt / 2 : 0;
        check(acc_out == expacc[7:0], "R6 running acc", acc_out, expacc);
      end
    end
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    phase++;
    case (tick_mode)
      0: ucyc_tick = 1'b1;
      1: ucyc_tick = (phase % 3) == 0;
      2: ucyc_tick = lf[0];
      default: ucyc_tick = 1'b0;
    endcase
    if (busy && ucyc_tick) tick_cnt++;
  end

  task automatic launch(input int unsigned p, input int unsigned ac);
    job_t j;
    param_in = p[7:0];
    acc_in   = ac[7:0];
    start    = 1'b1;
    j.p = p; j.ac = ac;
    sb_q.push_back(j);
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2 busy after start", busy, 1);
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  initial begin
    tick_mode = 0;
    repeat (3) @(negedge clk);
    check(!busy && !done && acc_out == 0, "R1 reset state",
          {busy, done, acc_out}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 shortest
    launch(0, 0);
    wait_done();
    @(negedge clk);

    // sparse ticks, R5
    tick_mode = 1;
    launch(0, 7);
    wait_done();

    // R7 hold after done
    repeat (5) @(negedge clk);
    check(acc_out == 0 && !busy && !done, "R7 held after done", acc_out, 0);

    // irregular ticks
    tick_mode = 2;
    launch(1, 200);
    wait_done();
    @(negedge clk);

    // R8: start while busy is ignored
    tick_mode = 1;
    launch(0, 50);
    repeat (10) @(negedge clk);
    param_in = 8'd3;
    acc_in   = 8'd1;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R8 still busy", busy, 1);
    wait_done();

    // R9: back-to-back start in the done cycle
    tick_mode = 0;
    launch(0, 3);
    check(sb_q.size() == 1, "R9 one job in flight", sb_q.size(), 1);
    wait_done();
    @(negedge clk);

    // R10 longest
    launch(255, 255);
    wait_done();
    @(negedge clk);
    check(sb_q.size() == 0, "R4 all jobs retired", sb_q.size(), 0);
    finish_run();
  end

endmodule